// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in whole nanoseconds for precision time protocol timestamping. On every datapath clock it adds a programmable increment made of an integer part and a 32-bit binary fraction of a nanosecond. The fraction builds up in its own accumulator and carries into the nanosecond count, so a rate such as 1.6 ns per clock is kept exactly over the long run. Because the count is a full 64 bits of nanoseconds, it never needs overflow handling in service.

Software reaches the block through a 32-bit register port. Each 64-bit quantity is split into a low and a high word. Writing the low word only stages it, and the high-word write commits all 64 bits in one cycle. Reading the low time word freezes the upper half, so the read of the high word that follows belongs to the same instant. An enable bit starts and stops the count. The live integer nanosecond value is driven out on a port for the timestamp capture logic. Software works out frequency corrections itself and writes a new increment.

Top module: `frac_ns_clock`

## Requirements
- R1: While running, each clock adds the increment to the {nanoseconds, 32-bit fraction} pair, so after N clocks from a load the time equals the loaded value plus floor(N × increment / 2^32), and each step of the time is the integer part or the integer part plus one.
- R2: The increment is fixed point: bits 63:32 hold whole nanoseconds and bits 31:0 the fraction. The value 0x1_99999999 gives 15 ns over 10 clocks, 0x3_33333333 gives 31 ns over 10 clocks, and 0x20_00000000 gives exactly 32 ns per clock.
- R3: A write to address 0 (time low) only stages its data and leaves the time unchanged. A write to address 1 (time high) loads {written data, staged low} into the time at that clock edge.
- R4: A write to address 2 (increment low) only stages its data. A write to address 3 (increment high) makes {written data, staged low} the active increment. Reads of addresses 2 and 3 return the low and high halves of the active increment, never the staged word.
- R5: A read of address 0 returns the low half of the live time and latches its high half. A later read of address 1 returns that latched half, even after the live time has moved on.
- R6: An increment of zero holds the time still while running.
- R7: Bit 0 of address 4 is the run enable. While it is clear the time holds, although loads still apply. Address 4 reads back {31 zeros, enable}.
- R8: A time load takes priority over the increment add in the same clock and clears the fraction accumulator.
- R9: After reset the time, fraction, active increment, staged words and latched high half are zero and the enable is clear.
- R10: Read data appears on reg_rdata after the clock edge that samples reg_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, one counter tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 time low, 1 time high, 2 increment low, 3 increment high, 4 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ns_now | output | 64 | Live integer nanosecond time for capture logic |

## Verification
A time-high write loads the time at the edge that samples it, so the new value is checked at the falling edge right after. Every count check after that waits a whole number of clocks counted from that load, with the fraction known to start at zero. A read result is due one edge after the strobe. The scoreboard queues each expected word when the read is issued and pops it at the next falling edge. Snapshot checks issue the low read in the cycle right after a load, so the expected word is exactly the loaded value. Rate-related results are compared against 96-bit fixed-point sums worked out in the bench.

// File: rtl/frac_ns_clock_pkg.sv
package frac_ns_clock_pkg;
   typedef enum logic [2:0] {
      ADR_TIME_LO = 3'd0,
      ADR_TIME_HI = 3'd1,
      ADR_INC_LO  = 3'd2,
      ADR_INC_HI  = 3'd3,
      ADR_CTRL    = 3'd4
   } tod_addr_e;

   localparam int unsigned ADDR_W = 3;
endpackage

// File: rtl/frac_ns_clock_regs.sv
module frac_ns_clock_regs
   import frac_ns_clock_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NS_W   = 64,
   parameter int unsigned INC_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [NS_W-1:0]   ns_now,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              load_stb,
   output logic [NS_W-1:0]   load_val,
   output logic [INC_W-1:0]  inc_act,
   output logic              run_en
);
   localparam int unsigned HI_NS_W  = NS_W - DATA_W;
   localparam int unsigned HI_INC_W = INC_W - DATA_W;

   logic [DATA_W-1:0]  time_lo_stage;
   logic [DATA_W-1:0]  inc_lo_stage;
   logic [HI_NS_W-1:0] snap_hi;

   // High time word commits the staged low word in the same cycle.
   assign load_stb = reg_wr && (reg_addr == ADR_TIME_HI);
   assign load_val = {reg_wdata[HI_NS_W-1:0], time_lo_stage};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_lo_stage <= '0;
         inc_lo_stage  <= '0;
         inc_act       <= '0;
         run_en        <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADR_TIME_LO: time_lo_stage <= reg_wdata;
            ADR_INC_LO:  inc_lo_stage  <= reg_wdata;
            ADR_INC_HI:  inc_act       <= {reg_wdata[HI_INC_W-1:0], inc_lo_stage};
            ADR_CTRL:    run_en        <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         snap_hi   <= '0;
      end else if (reg_rd) begin
         case (reg_addr)
            ADR_TIME_LO: begin
               reg_rdata <= ns_now[DATA_W-1:0];
               snap_hi   <= ns_now[NS_W-1:DATA_W];
            end
            ADR_TIME_HI: reg_rdata <= DATA_W'(snap_hi);
            ADR_INC_LO:  reg_rdata <= inc_act[DATA_W-1:0];
            ADR_INC_HI:  reg_rdata <= DATA_W'(inc_act[INC_W-1:DATA_W]);
            ADR_CTRL:    reg_rdata <= DATA_W'(run_en);
            default:     reg_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/frac_ns_clock_accum.sv
module frac_ns_clock_accum #(
   parameter int unsigned NS_W   = 64,
   parameter int unsigned FRAC_W = 32,
   parameter int unsigned INC_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             load_stb,
   input  logic [NS_W-1:0]  load_val,
   input  logic [INC_W-1:0] inc,
   output logic [NS_W-1:0]  ns_now
);
   localparam int unsigned INT_W = INC_W - FRAC_W;

   logic [NS_W-1:0] inc_int_ext;
   logic            frac_carry;
   logic [NS_W-1:0] ns_q;

   assign inc_int_ext = NS_W'(inc[INC_W-1:FRAC_W]);
   assign ns_now      = ns_q;

   generate
      if (FRAC_W > 0) begin : g_frac
         logic [FRAC_W-1:0] frac_q;
         logic [FRAC_W:0]   frac_sum;
         assign frac_sum   = {1'b0, frac_q} + {1'b0, inc[FRAC_W-1:0]};
         assign frac_carry = frac_sum[FRAC_W];
         always_ff @(posedge clk) begin
            if (!rst_n || load_stb) begin
               frac_q <= '0;
            end else if (run_en) begin
               frac_q <= frac_sum[FRAC_W-1:0];
            end
         end
      end else begin : g_int_only
         assign frac_carry = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q <= '0;
      end else if (load_stb) begin
         ns_q <= load_val;
      end else if (run_en) begin
         ns_q <= ns_q + inc_int_ext + NS_W'(frac_carry);
      end
   end

   if (INT_W > NS_W) begin : g_bad_int
      $error("increment integer part wider than time");
   end
endmodule

// File: rtl/frac_ns_clock.sv
module frac_ns_clock
   import frac_ns_clock_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FRAC_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [2:0]          reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [2*DATA_W-1:0] ns_now
);
   localparam int unsigned NS_W  = 2 * DATA_W;
   localparam int unsigned INC_W = 2 * DATA_W;

   if (FRAC_W >= INC_W) begin : g_bad_frac
      $error("fraction must leave room for an integer part");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("address width mismatch");
   end

   logic             load_stb;
   logic [NS_W-1:0]  load_val;
   logic [INC_W-1:0] inc_act;
   logic             run_en;

   frac_ns_clock_regs #(
      .DATA_W (DATA_W),
      .NS_W   (NS_W),
      .INC_W  (INC_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .ns_now    (ns_now),
      .reg_rdata (reg_rdata),
      .load_stb  (load_stb),
      .load_val  (load_val),
      .inc_act   (inc_act),
      .run_en    (run_en)
   );

   frac_ns_clock_accum #(
      .NS_W   (NS_W),
      .FRAC_W (FRAC_W),
      .INC_W  (INC_W)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .load_stb (load_stb),
      .load_val (load_val),
      .inc      (inc_act),
      .ns_now   (ns_now)
   );
endmodule

// File: rtl/frac_ns_clock_chk.sv
module frac_ns_clock_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FRAC_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic                reg_rd,
   input logic [2:0]          reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic [2*DATA_W-1:0] ns_now,
   input logic [2*DATA_W-1:0] inc_act,
   input logic                run_en
);
   localparam int unsigned NS_W = 2 * DATA_W;

   logic            hi_wr;
   logic [NS_W-1:0] int_part;
   assign hi_wr    = reg_wr && (reg_addr == 3'd1);
   assign int_part = NS_W'(inc_act[NS_W-1:FRAC_W]);

   a_r3_hi_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> ns_now[NS_W-1:DATA_W] == $past(reg_wdata));

   a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !hi_wr) |=> $stable(ns_now));

   a_r6_zero_inc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && inc_act == '0 && !hi_wr) |=> $stable(ns_now));

   a_r1_step_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !hi_wr) |=>
         ((ns_now - $past(ns_now)) >= $past(int_part)) &&
         ((ns_now - $past(ns_now)) <= $past(int_part) + 1));

   a_r10_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd4) |=> reg_rdata == DATA_W'($past(run_en)));
endmodule

bind frac_ns_clock frac_ns_clock_chk #(
   .DATA_W (DATA_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .ns_now    (ns_now),
   .inc_act   (inc_act),
   .run_en    (run_en)
);

// File: tb/frac_ns_clock_bench.sv
module frac_ns_clock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] ns_now;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   logic  rd_seen = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   frac_ns_clock u_frac_ns_clock (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ns_now    (ns_now)
   );

   always @(posedge clk) rd_seen <= reg_rd;

   // Monitor: a read result is due one edge after the strobe (R10).
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s R10 read: actual %h expected %h", t, reg_rdata, e);
         end
      end
   end

   task automatic chk64(input string t, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [63:0] after_ticks(input logic [63:0] v,
                                               input logic [63:0] inc, input int n);
      logic [95:0] acc;
      acc = {v, 32'h0} + 96'(inc) * 96'(n);
      return acc[95:32];
   endfunction

   initial begin
      logic [63:0] v;
      logic [63:0] hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      rd(3'd0, 32'h0, "R9 time lo");
      rd(3'd1, 32'h0, "R9 time hi");
      rd(3'd2, 32'h0, "R9 inc lo");
      rd(3'd3, 32'h0, "R9 inc hi");
      rd(3'd4, 32'h0, "R9 ctrl");
      chk64("R9 ns_now", ns_now, 64'h0);

      // R3 staged time write, R7 hold while disabled
      wr(3'd0, 32'h89ABCDEF);
      chk64("R3 low write staged only", ns_now, 64'h0);
      wr(3'd1, 32'h01234567);
      chk64("R3 high write loads", ns_now, 64'h0123456789ABCDEF);
      repeat (5) @(negedge clk);
      chk64("R7 disabled holds", ns_now, 64'h0123456789ABCDEF);

      // R4 staged increment
      wr(3'd2, 32'h99999999);
      rd(3'd2, 32'h0, "R4 staged low not active");
      wr(3'd3, 32'h1);
      rd(3'd2, 32'h99999999, "R4 inc lo active");
      rd(3'd3, 32'h1, "R4 inc hi active");

      // R7 enable, R8 load priority and fraction clear, R1/R2 1.6 ns
      wr(3'd4, 32'h1);
      rd(3'd4, 32'h1, "R7 ctrl readback");
      repeat (7) @(negedge clk);
      v = 64'h10_00000000;
      wr(3'd0, v[31:0]);
      wr(3'd1, v[63:32]);
      chk64("R8 load wins over add", ns_now, v);
      repeat (10) @(negedge clk);
      chk64("R2 R8 1.6ns x10", ns_now, v + 64'd15);
      repeat (990) @(negedge clk);
      chk64("R1 long-run 1000 ticks", ns_now, after_ticks(v, 64'h1_99999999, 1000));

      // R2 3.2 ns
      wr(3'd2, 32'h33333333);
      wr(3'd3, 32'h3);
      v = 64'h20_00000000;
      wr(3'd0, v[31:0]);
      wr(3'd1, v[63:32]);
      repeat (10) @(negedge clk);
      chk64("R2 3.2ns x10", ns_now, v + 64'd31);

      // R5 snapshot with 32 ns increment
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h20);
      v = 64'h5_FFFFFF00;
      wr(3'd0, v[31:0]);
      wr(3'd1, v[63:32]);
      rd(3'd0, 32'hFFFFFF00, "R5 low read live");
      repeat (20) @(negedge clk);
      rd(3'd1, 32'h5, "R5 high read latched");
      chk64("R2 32ns x22", ns_now, v + 64'd704);
      rd(3'd0, 32'h000001C0, "R5 second low read");
      rd(3'd1, 32'h6, "R5 second high read");

      // R6 zero increment stops
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h0);
      hold = ns_now;
      repeat (20) @(negedge clk);
      chk64("R6 zero inc holds", ns_now, hold);

      // R7 disable with nonzero increment
      wr(3'd3, 32'h20);
      wr(3'd4, 32'h0);
      hold = ns_now;
      repeat (10) @(negedge clk);
      chk64("R7 disable holds", ns_now, hold);
      rd(3'd4, 32'h0, "R7 ctrl cleared");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule